// File: doc/BRIEF.md
# Commit Slot Stall Attribution Counters

This block sits next to the retirement stage of an out-of-order core. At the end of each commit cycle it looks at how many of the available commit slots were actually filled. It then charges every empty slot to one cause, and only one: a misprediction squash, an empty reorder buffer (the front end did not deliver), a head instruction waiting on memory, or a head instruction still executing.

The retirement logic raises `cycleValid` once per commit cycle. With it, the retirement logic presents:

- the configured commit width;
- whether a squash is in progress;
- how many instructions retired in that cycle;
- the state of the reorder-buffer head at the point where retirement stopped.

The block keeps four saturating totals, one per cause, and a synchronous `clear` resets all four at once. Performance tools read the totals to split lost retirement bandwidth by cause.

Top module: `commit_slot_stall_ctr`

## Requirements
- R1: After reset all four counters read zero.
- R2: On a `cycleValid` cycle with `squashing` high, `cntMispredict` increases by `cfgWidth` and the other three counters keep their values.
- R3: On a `cycleValid` cycle without squash and with `headValid` low, `cntFetch` increases by `cfgWidth - numCommitted`.
- R4: On a `cycleValid` cycle without squash, with `headValid` high, `headReady` low and `headIsMem` high, `cntMemory` increases by `cfgWidth - numCommitted`.
- R5: On a `cycleValid` cycle without squash, with `headValid` high, `headReady` low and `headIsMem` low, `cntExec` increases by `cfgWidth - numCommitted`.
- R6: Without squash, a head that is present and ready leaves every counter unchanged. A remaining-slot count of zero also leaves every counter unchanged.
- R7: When `cycleValid` is low, no counter changes, whatever the other inputs are.
- R8: If `numCommitted` exceeds `cfgWidth`, the remaining-slot count is treated as zero and no counter changes. This input pattern is a protocol error.
- R9: Each counter is `CNT_WIDTH` bits wide (default 32). An addition that would pass all-ones leaves the counter at all-ones instead of wrapping.
- R10: `clear` sets all four counters to zero on the next edge and takes priority over any charge in the same cycle.
- R11: At most one counter changes in any cycle that is not a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of all counters |
| cfgWidth | input | $clog2(MAX_WIDTH+1) | Configured commit width, 1 to MAX_WIDTH |
| squashing | input | 1 | Commit is squashing after a mispredicted branch |
| numCommitted | input | $clog2(MAX_WIDTH+1) | Instructions retired this cycle |
| headValid | input | 1 | The reorder buffer holds a head instruction |
| headReady | input | 1 | The head instruction can retire |
| headIsMem | input | 1 | The head instruction is a load or store |
| cycleValid | input | 1 | End-of-commit-cycle strobe; inputs are sampled on it |
| cntMispredict | output | CNT_WIDTH | Slots lost to misprediction squashes |
| cntFetch | output | CNT_WIDTH | Slots lost to an empty reorder buffer |
| cntMemory | output | CNT_WIDTH | Slots lost to a head waiting on memory |
| cntExec | output | CNT_WIDTH | Slots lost to a head still executing |

## Verification
The properties assume that `cfgWidth` stays between 1 and `MAX_WIDTH` whenever `cycleValid` is high. They assume nothing else about the head flags, which may take any combination. The stimulus always draws the width from that range. It draws the retired count up to one above the width, so the over-commit protocol error of R8 is exercised together with the legal patterns. Squash, clear and strobe gaps are mixed in at random, so the totals are checked against a behavioural model through clears and across saturation with a narrowed counter width.

// File: rtl/commit_slot_stall_pkg.sv
package commit_slot_stall_pkg;

  typedef enum logic [1:0] {
    CAUSE_MISPREDICT = 2'd0,
    CAUSE_FETCH      = 2'd1,
    CAUSE_MEMORY     = 2'd2,
    CAUSE_EXEC       = 2'd3
  } causeT;

  localparam int NUM_CAUSES = 4;

  // Strobes from control to the counter datapath.
  typedef struct packed {
    logic                  clear;
    logic [NUM_CAUSES-1:0] charge;  // one-hot, indexed by causeT
  } strobeT;

endpackage

// File: rtl/commit_slot_stall_ctrl.sv
module commit_slot_stall_ctrl
  import commit_slot_stall_pkg::*;
#(
  parameter int MAX_WIDTH = 8,
  localparam int WB = $clog2(MAX_WIDTH + 1)
) (
  input  logic          clear,
  input  logic [WB-1:0] cfgWidth,
  input  logic          squashing,
  input  logic [WB-1:0] numCommitted,
  input  logic          headValid,
  input  logic          headReady,
  input  logic          headIsMem,
  input  logic          cycleValid,
  output strobeT        stb,
  output logic [WB-1:0] amount
);

  logic [WB-1:0] remaining;
  causeT         stallCause;
  logic          headStalled;

  always_comb begin
    remaining = (cfgWidth > numCommitted) ? (cfgWidth - numCommitted) : '0;
    headStalled = !headValid || !headReady;
    if (!headValid)    stallCause = CAUSE_FETCH;
    else if (headIsMem) stallCause = CAUSE_MEMORY;
    else               stallCause = CAUSE_EXEC;
  end

  always_comb begin
    stb        = '0;
    stb.clear  = clear;
    amount     = squashing ? cfgWidth : remaining;
    if (cycleValid && !clear) begin
      if (squashing) begin
        stb.charge[CAUSE_MISPREDICT] = 1'b1;
      end else if (headStalled && (remaining != '0)) begin
        stb.charge[stallCause] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/commit_slot_stall_dp.sv
module commit_slot_stall_dp
  import commit_slot_stall_pkg::*;
#(
  parameter int MAX_WIDTH = 8,
  parameter int CNT_WIDTH = 32,
  localparam int WB = $clog2(MAX_WIDTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobeT               stb,
  input  logic [WB-1:0]        amount,
  output logic [CNT_WIDTH-1:0] counts [NUM_CAUSES]
);

  logic [CNT_WIDTH:0] amountExt;
  assign amountExt = {{(CNT_WIDTH + 1 - WB){1'b0}}, amount};

  for (genvar i = 0; i < NUM_CAUSES; i++) begin : g_cnt
    logic [CNT_WIDTH:0] sum;
    assign sum = {1'b0, counts[i]} + amountExt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        counts[i] <= '0;
      end else if (stb.clear) begin
        counts[i] <= '0;
      end else if (stb.charge[i]) begin
        counts[i] <= sum[CNT_WIDTH] ? '1 : sum[CNT_WIDTH-1:0];
      end
    end
  end

endmodule

// File: rtl/commit_slot_stall_ctr.sv
module commit_slot_stall_ctr
  import commit_slot_stall_pkg::*;
#(
  parameter int MAX_WIDTH = 8,
  parameter int CNT_WIDTH = 32,
  localparam int WB = $clog2(MAX_WIDTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clear,
  input  logic [WB-1:0]        cfgWidth,
  input  logic                 squashing,
  input  logic [WB-1:0]        numCommitted,
  input  logic                 headValid,
  input  logic                 headReady,
  input  logic                 headIsMem,
  input  logic                 cycleValid,
  output logic [CNT_WIDTH-1:0] cntMispredict,
  output logic [CNT_WIDTH-1:0] cntFetch,
  output logic [CNT_WIDTH-1:0] cntMemory,
  output logic [CNT_WIDTH-1:0] cntExec
);

  strobeT               stb;
  logic [WB-1:0]        amount;
  logic [CNT_WIDTH-1:0] counts [NUM_CAUSES];

  commit_slot_stall_ctrl #(.MAX_WIDTH(MAX_WIDTH)) u_ctrl (
    .clear(clear), .cfgWidth(cfgWidth), .squashing(squashing),
    .numCommitted(numCommitted), .headValid(headValid), .headReady(headReady),
    .headIsMem(headIsMem), .cycleValid(cycleValid), .stb(stb), .amount(amount)
  );

  commit_slot_stall_dp #(.MAX_WIDTH(MAX_WIDTH), .CNT_WIDTH(CNT_WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .amount(amount), .counts(counts)
  );

  assign cntMispredict = counts[CAUSE_MISPREDICT];
  assign cntFetch      = counts[CAUSE_FETCH];
  assign cntMemory     = counts[CAUSE_MEMORY];
  assign cntExec       = counts[CAUSE_EXEC];

endmodule

// File: rtl/commit_slot_stall_chk.sv
module commit_slot_stall_chk #(
  parameter int MAX_WIDTH = 8,
  parameter int CNT_WIDTH = 32,
  localparam int WB = $clog2(MAX_WIDTH + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 clear,
  input logic [WB-1:0]        cfgWidth,
  input logic                 squashing,
  input logic [WB-1:0]        numCommitted,
  input logic                 headValid,
  input logic                 headReady,
  input logic                 cycleValid,
  input logic [CNT_WIDTH-1:0] cntMispredict,
  input logic [CNT_WIDTH-1:0] cntFetch,
  input logic [CNT_WIDTH-1:0] cntMemory,
  input logic [CNT_WIDTH-1:0] cntExec
);

  assert_squash_only_misp_R2: assert property (@(posedge clk) disable iff (!rstN)
    cycleValid && squashing && !clear |=>
      $stable(cntFetch) && $stable(cntMemory) && $stable(cntExec));

  assert_ready_head_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    cycleValid && !clear && !squashing && headValid && headReady |=>
      $stable(cntMispredict) && $stable(cntFetch) && $stable(cntMemory) && $stable(cntExec));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !cycleValid && !clear |=>
      $stable(cntMispredict) && $stable(cntFetch) && $stable(cntMemory) && $stable(cntExec));

  assert_overcommit_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    cycleValid && !clear && !squashing && (numCommitted >= cfgWidth) |=>
      $stable(cntMispredict) && $stable(cntFetch) && $stable(cntMemory) && $stable(cntExec));

  assert_saturate_misp_R9: assert property (@(posedge clk) disable iff (!rstN)
    !clear && (cntMispredict == '1) |=> cntMispredict == '1);

  assert_saturate_fetch_R9: assert property (@(posedge clk) disable iff (!rstN)
    !clear && (cntFetch == '1) |=> cntFetch == '1);

  assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (cntMispredict == '0) && (cntFetch == '0) && (cntMemory == '0) && (cntExec == '0));

  assert_one_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    !clear |=> $countones({cntMispredict != $past(cntMispredict), cntFetch != $past(cntFetch),
                           cntMemory != $past(cntMemory), cntExec != $past(cntExec)}) <= 1);

endmodule

bind commit_slot_stall_ctr commit_slot_stall_chk #(
  .MAX_WIDTH(MAX_WIDTH), .CNT_WIDTH(CNT_WIDTH)
) u_chk (
  .clk(clk), .rstN(rstN), .clear(clear), .cfgWidth(cfgWidth), .squashing(squashing),
  .numCommitted(numCommitted), .headValid(headValid), .headReady(headReady),
  .cycleValid(cycleValid), .cntMispredict(cntMispredict), .cntFetch(cntFetch),
  .cntMemory(cntMemory), .cntExec(cntExec)
);

// File: tb/commit_slot_stall_ctr_bench.sv
module commit_slot_stall_ctr_bench;
  localparam int MW = 8;
  localparam int CW = 6;  // narrowed so saturation is reachable
  localparam int WB = $clog2(MW + 1);
  localparam longint CMAX = (64'd1 << CW) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic rstN, clear, squashing, headValid, headReady, headIsMem, cycleValid;
  logic [WB-1:0] cfgWidth, numCommitted;
  logic [CW-1:0] cntMispredict, cntFetch, cntMemory, cntExec;

  commit_slot_stall_ctr #(.MAX_WIDTH(MW), .CNT_WIDTH(CW)) u_commit_slot_stall_ctr (
    .clk(clk), .rstN(rstN), .clear(clear), .cfgWidth(cfgWidth), .squashing(squashing),
    .numCommitted(numCommitted), .headValid(headValid), .headReady(headReady),
    .headIsMem(headIsMem), .cycleValid(cycleValid), .cntMispredict(cntMispredict),
    .cntFetch(cntFetch), .cntMemory(cntMemory), .cntExec(cntExec)
  );

  longint mdl [4];
  int errors = 0;
  int checks = 0;

  task automatic checkOne(string req, string name, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, name, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    checkOne(req, "mispredict", longint'(cntMispredict), mdl[0]);
    checkOne(req, "fetch",      longint'(cntFetch),      mdl[1]);
    checkOne(req, "memory",     longint'(cntMemory),     mdl[2]);
    checkOne(req, "exec",       longint'(cntExec),       mdl[3]);
  endtask

  // Drive one cycle at a negedge, advance the model, compare at the next negedge.
  task automatic step(int w, int sq, int nc, int hv, int hr, int hm, int cv, int clr, string req);
    int rem;
    int idx;
    cfgWidth = WB'(w); squashing = sq[0]; numCommitted = WB'(nc);
    headValid = hv[0]; headReady = hr[0]; headIsMem = hm[0];
    cycleValid = cv[0]; clear = clr[0];
    rem = (w > nc) ? w - nc : 0;
    idx = -1;
    if (clr != 0) begin
      foreach (mdl[i]) mdl[i] = 0;
    end else if (cv != 0) begin
      if (sq != 0) begin idx = 0; rem = w; end
      else if (rem > 0 && (hv == 0 || hr == 0)) idx = (hv == 0) ? 1 : ((hm != 0) ? 2 : 3);
      if (idx >= 0) mdl[idx] = (mdl[idx] + rem > CMAX) ? CMAX : mdl[idx] + rem;
    end
    @(negedge clk);
    checkAll(req);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    foreach (mdl[i]) mdl[i] = 0;
    rstN = 1'b0; clear = 1'b0; squashing = 1'b0; headValid = 1'b0;
    headReady = 1'b0; headIsMem = 1'b0; cycleValid = 1'b0;
    cfgWidth = WB'(4); numCommitted = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    step(5, 1, 2, 1, 0, 1, 1, 0, "R2");   // mispredict += 5
    step(8, 0, 3, 0, 0, 0, 1, 0, "R3");   // fetch += 5
    step(4, 0, 1, 1, 0, 1, 1, 0, "R4");   // memory += 3
    step(6, 0, 0, 1, 0, 0, 1, 0, "R5");   // exec += 6
    step(6, 0, 2, 1, 1, 0, 1, 0, "R6");   // ready head: nothing
    step(3, 0, 3, 0, 0, 0, 1, 0, "R6");   // full width: nothing
    step(8, 1, 0, 0, 0, 0, 0, 0, "R7");   // no strobe: nothing
    step(8, 0, 0, 1, 0, 1, 0, 0, "R7");
    step(3, 0, 7, 0, 0, 0, 1, 0, "R8");   // over-commit: nothing
    step(2, 0, 3, 1, 0, 0, 1, 0, "R8");
    step(8, 1, 0, 0, 0, 0, 1, 1, "R10");  // clear beats squash
    for (int k = 0; k < 9; k++) step(8, 1, 0, 0, 0, 0, 1, 0, "R9");
    for (int k = 0; k < 9; k++) step(8, 0, 0, 0, 0, 0, 1, 0, "R9");
    step(1, 0, 0, 0, 0, 0, 1, 1, "R10");

    for (int k = 0; k < 400; k++) begin
      int w;
      w = 1 + int'($urandom % MW);
      step(w, ($urandom % 8) == 0, int'($urandom % (w + 2)), int'($urandom % 2),
           int'($urandom % 2), int'($urandom % 2), ($urandom % 4) != 0,
           ($urandom % 40) == 0, "R11");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule